// File: doc/BRIEF.md
# Late-Data Detecting Result Register

This block is a W-bit result register that notices when its input settled too late for the regular clock edge. The main register captures `d` on the rising edge of `clk`. A shadow register captures the same `d` on the rising edge of `clk_dly`, a copy of the clock that lags `clk` by part of a period. Because of the lag, the shadow copy holds the value that the data path eventually settled to.

On the next `clk` edge the two copies are compared bit by bit. If they match, the main register simply loads the next operand. If they differ, the main register reloads itself from the shadow copy instead of from `d`, and `err` is raised for one cycle. A hold controller uses that flag to re-execute the operation as a two-cycle operation, keeping the operand steady during the repeat.

The delayed edge must fall before the next operand can reach `d`. That short-path rule belongs to the surrounding design.

Top module: `late_catch_reg`

## Requirements
- R1: While `rst_n` is low, `q` and `err` are 0. The shadow copy is also cleared, so the first comparison after reset is released does not raise `err`.
- R2: If the value at `d` on a `clk` rising edge equals the value the shadow takes at the following `clk_dly` edge, `q` shows the value captured at the `clk` edge. `err` is 0 in the cycle after the next `clk` edge.
- R3: If the main and shadow copies differ at a `clk` rising edge, `err` is 1 for the cycle that starts at that edge.
- R4: On the edge where a mismatch is detected, `q` takes the shadow value. The value on `d` at that edge is ignored.
- R5: After a flagged operation whose settled operand stays on `d`, `err` returns to 0 at the next `clk` edge. It is a single-cycle pulse per mismatch.
- R6: A difference in any single bit raises `err`, including bit 0 and bit W-1, and so does a difference in several bits at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Regular clock; the main register and the error flag update on its rising edge |
| clk_dly | input | 1 | Delayed copy of `clk`; the shadow register samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| d | input | W | Result arriving from the data path |
| q | output | W | Registered result, corrected one cycle after a mismatch |
| err | output | 1 | One-cycle flag for each detected late arrival |

## Verification
Operands are driven with an early value before the `clk` edge and a settled value before the `clk_dly` edge. On-time cases use equal early and settled values: zero, all ones and a mixed pattern. These show that pass-through raises no false flag. Late cases differ only in bit 0, only in the top bit, or in many bits, which shows that every position reaches the comparator. One late case puts an unrelated value on `d` exactly at the restore edge, which separates a restore taken from the shadow copy from one taken from `d`.

// File: rtl/late_catch_reg.sv
module late_catch_reg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         clk_dly,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         err
);

  logic [W-1:0] main_q;
  logic [W-1:0] shd_q;
  logic         err_q;
  logic         mism;

  assign mism = |(main_q ^ shd_q);

  always_ff @(posedge clk_dly or negedge rst_n) begin
    if (!rst_n) shd_q <= '0;
    else        shd_q <= d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_q <= '0;
      err_q  <= 1'b0;
    end else begin
      err_q  <= mism;
      main_q <= mism ? shd_q : d;
    end
  end

  assign q   = main_q;
  assign err = err_q;

  // R3
  late_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q != shd_q) |=> err);

  // R4
  restore_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (q == $past(shd_q)));

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q == shd_q) |=> (q == $past(d)));

  // R5
  quiet_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (main_q == shd_q) |=> !err);

endmodule

// File: tb/tb_late_catch_reg.sv
`timescale 1ns/1ps
module tb_late_catch_reg;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         clk_dly = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] d = '0;
  logic [W-1:0] q;
  logic         err;

  int n_chk = 0;
  int n_bad = 0;

  late_catch_reg #(.W(W)) dut (
    .clk(clk), .clk_dly(clk_dly), .rst_n(rst_n), .d(d), .q(q), .err(err)
  );

  initial forever #2.5 clk = ~clk;
  initial begin
    #1.5;
    forever #2.5 clk_dly = ~clk_dly;
  end

  task automatic chk(input bit ok, input string req, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // early: value present at the clk edge; good: settled value seen by the shadow
  task automatic run_op(input logic [W-1:0] early, input logic [W-1:0] good,
                        input bit poke, input logic [W-1:0] junk, input string req);
    logic exp_err;
    exp_err = (early != good);
    @(posedge clk); #4;
    d = early;
    @(posedge clk); #0.5;
    d = good;
    #2.5;
    chk(q == early, {req, " main capture"}, q, early);
    if (poke) begin
      #1;
      d = junk;
      @(posedge clk); #0.5;
      d = good;
      #2.5;
    end else begin
      @(posedge clk); #3;
    end
    chk(q == good, {req, " result"}, q, good);
    chk(err == exp_err, {req, " flag"}, W'(err), W'(exp_err));
    @(posedge clk); #3;
    chk(err == 1'b0, exp_err ? "R5 flag clears" : "R2 flag stays low", W'(err), '0);
    chk(q == good, {req, " result held"}, q, good);
  endtask

  task automatic t_reset();
    #1;
    d = 16'hBEEF;
    @(posedge clk); #3;
    chk(q == '0, "R1 q cleared", q, '0);
    chk(err == 1'b0, "R1 err cleared", W'(err), '0);
    @(posedge clk); #3;
    rst_n = 1'b1;
    @(posedge clk); #3;
    chk(err == 1'b0, "R1 first compare quiet", W'(err), '0);
    chk(q == 16'hBEEF, "R1 first capture", q, 16'hBEEF);
    @(posedge clk); #3;
    chk(err == 1'b0, "R1 second compare quiet", W'(err), '0);
  endtask

  task automatic t_on_time();
    run_op(16'h0000, 16'h0000, 1'b0, '0, "R2 zero");
    run_op(16'hFFFF, 16'hFFFF, 1'b0, '0, "R2 ones");
    run_op(16'h5A3C, 16'h5A3C, 1'b0, '0, "R2 mixed");
  endtask

  task automatic t_late();
    run_op(16'h1234, 16'h1235, 1'b0, '0, "R3 R6 bit0");
    run_op(16'h0F0F, 16'h8F0F, 1'b0, '0, "R3 R6 msb");
    run_op(16'hAAAA, 16'h5555, 1'b0, '0, "R3 R6 multi");
  endtask

  task automatic t_restore_ignores_d();
    run_op(16'h00F0, 16'h0FF0, 1'b1, 16'hDEAD, "R4 restore from shadow");
  endtask

  initial begin
    #(200000 * 5);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    t_reset();
    t_on_time();
    t_late();
    t_restore_ignores_d();
    t_on_time();
    summary();
  end
endmodule